// File: doc/BRIEF.md
# Message-out phase sequencer for a parallel-bus storage controller

This block steers the phase sequence that follows a successful selection. As a target, it decides how many message bytes to collect before it moves to the command phase. When the extended-message feature is enabled and the selection carried attention, the live attention line is sampled as the first message byte completes. Attention still active means two further message bytes are collected; attention inactive means the block moves straight to command phase. With the feature disabled, exactly one message byte is taken.

As an initiator, the block tracks the same exchange from the other side. After it has sent the first message byte, it waits for the target's next phase report. A command phase report moves it to command phase. A report of any other phase, with the feature disabled, aborts the selection with a one-cycle pulse. With the feature enabled, the target is allowed to ask for more message bytes.

The feature enable is a register bit that the host writes through a strobe. It is also driven out as a status bit, because the same enable turns on recognition of an additional command group elsewhere in the controller. Bus arbitration, the REQ/ACK handshake and command decoding all lie outside this block.

Top module: `scsi_msgout_seq`

## Requirements
- R1: When feat_wr is high at a clock edge, feat_en takes the value of feat_wdata after that edge. Reset clears feat_en to 0.
- R2: A selection (sel_valid high while the block is idle) with sel_atn=1 raises phase_msgout after the next edge, in either role.
- R3: A selection with sel_atn=0 skips message-out and raises phase_cmd after the next edge, in either role.
- R4: Target role (role_init=0) with feat_en=0: the first byte_rcvd strobe in message-out moves the block to command phase after that edge.
- R5: Target role with feat_en=1: if atn_live=1 at the first byte_rcvd, phase_msgout stays high for exactly two more byte_rcvd strobes, and phase_cmd rises after the third byte in total.
- R6: Target role with feat_en=1: if atn_live=0 at the first byte_rcvd, the block enters command phase after that edge.
- R7: Initiator role (role_init=1) with feat_en=0: after the first byte, a tgt_phase_valid strobe with tgt_phase_cmd=0 gives abort_pulse=1 for exactly one cycle with both phase outputs low, and the block returns to idle.
- R8: Initiator role: after a byte, tgt_phase_valid with tgt_phase_cmd=1 enters command phase. With feat_en=1, tgt_phase_cmd=0 returns the block to message-out and raises no abort.
- R9: seq_done in command phase returns the block to idle (both phase outputs low). sel_valid has no effect while the block is not idle.
- R10: phase_msgout and phase_cmd are never high together.
- R11: atn_live is ignored at every point except the first message byte, so it cannot change the number of extra bytes collected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| feat_wr | input | 1 | Write strobe for the feature enable |
| feat_wdata | input | 1 | Value written to the feature enable |
| role_init | input | 1 | 1 = initiator role, 0 = target role; sampled at selection |
| sel_valid | input | 1 | One-cycle selection event |
| sel_atn | input | 1 | Attention flag that comes with the selection event |
| atn_live | input | 1 | Live attention line |
| byte_rcvd | input | 1 | Message byte completed strobe |
| tgt_phase_valid | input | 1 | Initiator role: strobe reporting the target's next phase |
| tgt_phase_cmd | input | 1 | With tgt_phase_valid: 1 if the reported phase is command |
| seq_done | input | 1 | Command phase finished; return to idle |
| phase_msgout | output | 1 | Message-out phase active |
| phase_cmd | output | 1 | Command phase active |
| abort_pulse | output | 1 | One-cycle selection abort |
| feat_en | output | 1 | Extended-message and command-group feature enable status |

## Verification
On every cycle, the assertions check that the two phase outputs are mutually exclusive, that the feature bit loads, that a selection without attention goes straight to command phase, that the outcome of the first target byte follows the feature bit and the attention line, and that an abort lasts one cycle and leaves the block idle. Some behaviour shows only in the bench's scenarios: the exact count of three bytes in the extended case, the fact that attention toggling on the later bytes has no effect, and the fact that a second selection is ignored mid-sequence. The bench checks these with directed sequences and with randomised combinations of role, feature bit and attention levels.

// File: rtl/scsi_msgout_pkg.sv
package scsi_msgout_pkg;
  typedef enum logic [1:0] {
    T_IDLE = 2'd0,
    T_MSG  = 2'd1,
    T_CMD  = 2'd2
  } tgt_st_e;

  typedef enum logic [1:0] {
    I_IDLE = 2'd0,
    I_MSG  = 2'd1,
    I_WAIT = 2'd2,
    I_CMD  = 2'd3
  } ini_st_e;
endpackage

// File: rtl/msgout_rst_sync.sv
module msgout_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/msgout_feat_reg.sv
module msgout_feat_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic wr,
  input  logic wdata,
  output logic feat
);
  logic feat_q, feat_d;

  always_comb begin
    feat_d = feat_q;
    if (wr) feat_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) feat_q <= 1'b0;
    else        feat_q <= feat_d;
  end

  assign feat = feat_q;

  p_feat_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (feat == $past(wdata)));
endmodule

// File: rtl/msgout_tgt_fsm.sv
module msgout_tgt_fsm
  import scsi_msgout_pkg::*;
#(
  parameter int EXTRA_BYTES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic sel_atn,
  input  logic feat,
  input  logic atn_live,
  input  logic byte_rcvd,
  input  logic done,
  output logic idle,
  output logic msgout,
  output logic cmd
);
  localparam int CNT_W = (EXTRA_BYTES > 1) ? $clog2(EXTRA_BYTES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(EXTRA_BYTES - 1);

  tgt_st_e          st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ext_q, ext_d;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    ext_d = ext_q;
    case (st_q)
      T_IDLE: begin
        if (start) begin
          st_d  = sel_atn ? T_MSG : T_CMD;
          cnt_d = '0;
          ext_d = 1'b0;
        end
      end
      T_MSG: begin
        if (byte_rcvd) begin
          if (!ext_q) begin
            if (feat && atn_live) begin
              ext_d = 1'b1;
              cnt_d = '0;
            end else begin
              st_d = T_CMD;
            end
          end else if (cnt_q == LAST) begin
            st_d  = T_CMD;
            ext_d = 1'b0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      T_CMD: begin
        if (done) st_d = T_IDLE;
      end
      default: st_d = T_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= T_IDLE;
      cnt_q <= '0;
      ext_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      ext_q <= ext_d;
    end
  end

  assign idle   = (st_q == T_IDLE);
  assign msgout = (st_q == T_MSG);
  assign cmd    = (st_q == T_CMD);

  p_one_byte_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (msgout && !ext_q && byte_rcvd && !feat) |=> cmd);
  p_ext_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (msgout && !ext_q && byte_rcvd && feat && atn_live) |=> msgout);
  p_no_atn_cmd_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (msgout && !ext_q && byte_rcvd && !atn_live) |=> cmd);
endmodule

// File: rtl/msgout_ini_chk.sv
module msgout_ini_chk
  import scsi_msgout_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic sel_atn,
  input  logic feat,
  input  logic byte_rcvd,
  input  logic ph_valid,
  input  logic ph_cmd,
  input  logic done,
  output logic idle,
  output logic msgout,
  output logic cmd,
  output logic abort
);
  ini_st_e st_q, st_d;
  logic    abort_q, abort_d;

  always_comb begin
    st_d    = st_q;
    abort_d = 1'b0;
    case (st_q)
      I_IDLE: if (start) st_d = sel_atn ? I_MSG : I_CMD;
      I_MSG:  if (byte_rcvd) st_d = I_WAIT;
      I_WAIT: begin
        if (ph_valid) begin
          if (ph_cmd)    st_d = I_CMD;
          else if (feat) st_d = I_MSG;
          else begin
            st_d    = I_IDLE;
            abort_d = 1'b1;
          end
        end
      end
      I_CMD:  if (done) st_d = I_IDLE;
      default: st_d = I_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= I_IDLE;
      abort_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      abort_q <= abort_d;
    end
  end

  assign idle   = (st_q == I_IDLE);
  assign msgout = (st_q == I_MSG) || (st_q == I_WAIT);
  assign cmd    = (st_q == I_CMD);
  assign abort  = abort_q;

  p_abort_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    abort |-> (idle && !$past(abort)));
  p_abort_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == I_WAIT && ph_valid && !ph_cmd && !feat) |=> abort);
  p_feat_retry_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == I_WAIT && ph_valid && !ph_cmd && feat) |=> (msgout && !abort));
endmodule

// File: rtl/scsi_msgout_seq.sv
module scsi_msgout_seq #(
  parameter int EXTRA_BYTES = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic feat_wr,
  input  logic feat_wdata,
  input  logic role_init,
  input  logic sel_valid,
  input  logic sel_atn,
  input  logic atn_live,
  input  logic byte_rcvd,
  input  logic tgt_phase_valid,
  input  logic tgt_phase_cmd,
  input  logic seq_done,
  output logic phase_msgout,
  output logic phase_cmd,
  output logic abort_pulse,
  output logic feat_en
);
  logic rst_i_n;
  logic t_idle, t_msg, t_cmd;
  logic i_idle, i_msg, i_cmd, i_abort;
  logic all_idle, t_start, i_start;

  msgout_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n)
  );

  msgout_feat_reg u_feat (
    .clk(clk), .rst_n(rst_i_n), .wr(feat_wr), .wdata(feat_wdata), .feat(feat_en)
  );

  assign all_idle = t_idle && i_idle;
  assign t_start  = sel_valid && all_idle && !role_init;
  assign i_start  = sel_valid && all_idle &&  role_init;

  msgout_tgt_fsm #(.EXTRA_BYTES(EXTRA_BYTES)) u_tgt (
    .clk(clk), .rst_n(rst_i_n), .start(t_start), .sel_atn(sel_atn),
    .feat(feat_en), .atn_live(atn_live), .byte_rcvd(byte_rcvd),
    .done(seq_done), .idle(t_idle), .msgout(t_msg), .cmd(t_cmd)
  );

  msgout_ini_chk u_ini (
    .clk(clk), .rst_n(rst_i_n), .start(i_start), .sel_atn(sel_atn),
    .feat(feat_en), .byte_rcvd(byte_rcvd), .ph_valid(tgt_phase_valid),
    .ph_cmd(tgt_phase_cmd), .done(seq_done), .idle(i_idle),
    .msgout(i_msg), .cmd(i_cmd), .abort(i_abort)
  );

  assign phase_msgout = t_msg || i_msg;
  assign phase_cmd    = t_cmd || i_cmd;
  assign abort_pulse  = i_abort;

  p_phase_excl_r10: assert property (@(posedge clk) disable iff (!rst_i_n)
    !(phase_msgout && phase_cmd));
  p_sel_atn_r2: assert property (@(posedge clk) disable iff (!rst_i_n)
    (sel_valid && all_idle && sel_atn) |=> phase_msgout);
  p_sel_noatn_r3: assert property (@(posedge clk) disable iff (!rst_i_n)
    (sel_valid && all_idle && !sel_atn) |=> phase_cmd);
  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_i_n)
    (phase_cmd && seq_done) |=> (!phase_cmd && !phase_msgout));
endmodule

// File: tb/scsi_msgout_seq_tb_top.sv
module scsi_msgout_seq_tb_top;
  logic clk = 1'b0;
  logic rst_n;
  logic feat_wr, feat_wdata, role_init, sel_valid, sel_atn, atn_live;
  logic byte_rcvd, tgt_phase_valid, tgt_phase_cmd, seq_done;
  logic phase_msgout, phase_cmd, abort_pulse, feat_en;
  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  scsi_msgout_seq dut_i (
    .clk(clk), .rst_n(rst_n), .feat_wr(feat_wr), .feat_wdata(feat_wdata),
    .role_init(role_init), .sel_valid(sel_valid), .sel_atn(sel_atn),
    .atn_live(atn_live), .byte_rcvd(byte_rcvd),
    .tgt_phase_valid(tgt_phase_valid), .tgt_phase_cmd(tgt_phase_cmd),
    .seq_done(seq_done), .phase_msgout(phase_msgout), .phase_cmd(phase_cmd),
    .abort_pulse(abort_pulse), .feat_en(feat_en)
  );

  function automatic int exp_bytes(bit feat, bit satn, bit atn1);
    if (!satn) return 0;
    return (feat && atn1) ? 3 : 1;
  endfunction

  task automatic chk(string req, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%b exp=%b (msgout,cmd,abort,feat)", req, act, exp);
    end
  endtask

  function automatic logic [3:0] outs();
    return {phase_msgout, phase_cmd, abort_pulse, feat_en};
  endfunction

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic clear_ins();
    feat_wr = 0; sel_valid = 0; byte_rcvd = 0;
    tgt_phase_valid = 0; seq_done = 0;
  endtask

  task automatic write_feat(bit v);
    feat_wr = 1; feat_wdata = v; tick(); clear_ins();
    chk("R1", outs(), {3'b000, v});
  endtask

  task automatic select(bit role, bit satn);
    role_init = role; sel_valid = 1; sel_atn = satn; tick(); clear_ins();
    chk(satn ? "R2" : "R3", outs(), {satn, !satn, 1'b0, feat_en});
  endtask

  task automatic finish_cmd(bit f);
    seq_done = 1; tick(); clear_ins();
    chk("R9", outs(), {3'b000, f});
  endtask

  task automatic tgt_run(bit f, bit satn, bit atn1);
    int n = exp_bytes(f, satn, atn1);
    write_feat(f);
    select(1'b0, satn);
    for (int k = 0; k < n; k++) begin
      atn_live = (k == 0) ? atn1 : 1'($urandom_range(0, 1));
      byte_rcvd = 1; tick(); clear_ins();
      if (k == n - 1)
        chk(f ? (atn1 ? "R5" : "R6") : "R4", outs(), {2'b01, 1'b0, f});
      else
        chk(k == 0 ? "R5" : "R11", outs(), {2'b10, 1'b0, f});
    end
    finish_cmd(f);
  endtask

  task automatic ini_run(bit f, bit satn, bit rep_cmd);
    write_feat(f);
    select(1'b1, satn);
    if (satn) begin
      byte_rcvd = 1; tick(); clear_ins();
      chk("R8", outs(), {2'b10, 1'b0, f});
      tgt_phase_valid = 1; tgt_phase_cmd = rep_cmd; tick(); clear_ins();
      if (rep_cmd) chk("R8", outs(), {2'b01, 1'b0, f});
      else if (f) begin
        chk("R8", outs(), {2'b10, 1'b0, f});
        byte_rcvd = 1; tick(); clear_ins();
        tgt_phase_valid = 1; tgt_phase_cmd = 1; tick(); clear_ins();
        chk("R8", outs(), {2'b01, 1'b0, f});
      end else begin
        chk("R7", outs(), {2'b00, 1'b1, f});
        tick();
        chk("R7", outs(), {2'b00, 1'b0, f});
        return;
      end
    end
    finish_cmd(f);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    rst_n = 0; clear_ins(); feat_wdata = 0; role_init = 0; sel_atn = 0;
    atn_live = 0; tgt_phase_cmd = 0;
    repeat (3) tick();
    chk("R1", outs(), 4'b0000);
    rst_n = 1;
    repeat (4) tick();
    chk("R1", outs(), 4'b0000);

    tgt_run(0, 1, 1);
    tgt_run(1, 1, 1);
    tgt_run(1, 1, 0);
    tgt_run(1, 0, 1);
    ini_run(0, 1, 0);
    ini_run(0, 1, 1);
    ini_run(1, 1, 0);
    ini_run(0, 0, 0);

    // R9: a second selection in message-out is ignored
    write_feat(0);
    select(1'b0, 1'b1);
    role_init = 1; sel_valid = 1; sel_atn = 0; tick(); clear_ins();
    chk("R9", outs(), 4'b1000);
    atn_live = 0; byte_rcvd = 1; tick(); clear_ins();
    chk("R4", outs(), 4'b0100);
    finish_cmd(0);

    // R1: reset clears the feature bit
    write_feat(1);
    rst_n = 0; tick(); tick();
    chk("R1", outs(), 4'b0000);
    rst_n = 1; repeat (4) tick();

    for (int i = 0; i < 60; i++) begin
      bit f = 1'($urandom_range(0, 1));
      bit s = 1'($urandom_range(0, 3) != 0);
      bit a = 1'($urandom_range(0, 1));
      if ($urandom_range(0, 1)) tgt_run(f, s, a);
      else                      ini_run(f, s, a);
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule